// File: doc/BRIEF.md
# Asynchronous Pulse Catcher with Request Synchronizer

This block accepts an active-low asynchronous event line and turns each event into a request level that a rising-edge controller can use safely. In pulse mode the event may be far narrower than one clock period. A catching flop is set directly by the falling event line and keeps that level until the controller acknowledges it. A second flop samples the caught level on the falling clock edge. That leaves half a period for the request to settle before the controller's next rising edge.

The controller comes with the block. It is a small service machine with the states idle, service and acknowledge. It sees the request, stays in service for a programmable number of cycles, and then raises a registered acknowledge for one cycle. That acknowledge, combined with the system reset, clears the catching flop. An event that lands while the acknowledge is high is kept, so it is serviced again.

In level mode the event line is held much longer than a clock period. The catching flop is then left out, and the inverted line is sampled straight on the falling edge. Each new assertion of the level is serviced once.

Top module: `pc_pulse_sync`

## Requirements
- R1: With `rst` high, `req` and `ack` are 0 one edge later. An event on `evt_n` that begins and ends while `rst` is high is discarded: after reset no request and no acknowledge appear.
- R2: `req` changes only at falling clock edges. In pulse mode, an event of any width, including one of 1 ns that is shorter than half a period, that starts while the block is idle sets `req` to 1 at the next falling edge and not before it.
- R3: In pulse mode, once `req` is 1 it stays 1 until the cycle in which `ack` is 1.
- R4: The controller leaves idle at the first rising edge that sees `req` = 1. It spends `SVC_LEN` cycles in service and then drives `ack` = 1 for exactly one cycle. An event starting in the first half of cycle c gives `ack` in cycle c+1+`SVC_LEN`, and one starting in the second half gives it a cycle later. Each caught event gives exactly one acknowledge.
- R5: In pulse mode the acknowledge clears the caught level, so `req` returns to 0 at the falling edge inside the acknowledge cycle when no new event has arrived.
- R6: In pulse mode an event that arrives while `ack` is 1 is not lost. It yields one further acknowledge, timed as in R4.
- R7: In level mode (`MODE` = MODE_LEVEL), `req` equals the inverse of `evt_n` sampled at each falling edge. Each transition of `evt_n` to low, held for several cycles, gives exactly one acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the controller uses rising edges, the synchronizer falling edges |
| rst | input | 1 | Synchronous active-high reset; also clears the catching flop |
| evt_n | input | 1 | Active-low asynchronous event (pulse or level depending on `MODE`) |
| req | output | 1 | Synchronized request level |
| ack | output | 1 | One-cycle acknowledge from the service controller |

## Verification
The bench builds two copies of the block. The first is in pulse mode with `SVC_LEN` = 2. Its multi-cycle service window gives the service counter real work and leaves room to land events in either half of the acknowledge cycle. The second is in level mode with `SVC_LEN` = 1. It shows that a held level is serviced once and that `req` follows the line at falling edges. Random event widths from 1 ns to 8 ns, with start points in both clock halves, exercise the latency rule of R4 in the pulse-mode copy.

// File: rtl/pc_pkg.sv
package pc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SERVICE = 2'd1,
        ST_ACK     = 2'd2
    } svc_state_e;

    typedef enum logic {
        MODE_PULSE = 1'b0,
        MODE_LEVEL = 1'b1
    } catch_mode_e;

    typedef struct packed {
        svc_state_e st;
        logic       ack;
    } svc_reg_t;

    function automatic svc_state_e svc_next(input svc_state_e cur,
                                            input logic       trig,
                                            input logic       last);
        svc_state_e nxt;
        nxt = cur;
        case (cur)
            ST_IDLE:    if (trig) nxt = ST_SERVICE;
            ST_SERVICE: if (last) nxt = ST_ACK;
            ST_ACK:     nxt = trig ? ST_SERVICE : ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/pc_catch_cell.sv
module pc_catch_cell (
    input  logic clr,
    input  logic rst_win,
    input  logic evt_n,
    output logic caught
);
    always_ff @(posedge clr or negedge evt_n) begin
        if (rst_win)
            caught <= 1'b0;
        else if (!evt_n)
            caught <= 1'b1;
        else
            caught <= 1'b0;
    end
endmodule

// File: rtl/pc_fall_sync.sv
module pc_fall_sync (
    input  logic clk,
    input  logic rst,
    input  logic src,
    output logic req
);
    always_ff @(negedge clk) begin
        if (rst)
            req <= 1'b0;
        else
            req <= src;
    end
endmodule

// File: rtl/pc_consumer.sv
module pc_consumer
    import pc_pkg::*;
#(
    parameter catch_mode_e MODE    = MODE_PULSE,
    parameter int unsigned SVC_LEN = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic ack
);
    localparam int unsigned CW = (SVC_LEN < 2) ? 1 : $clog2(SVC_LEN);
    localparam logic [CW-1:0] LAST_CNT = CW'(SVC_LEN - 1);

    svc_reg_t   cur, nxt;
    logic [CW-1:0] cnt;
    logic       trig;
    logic       last;

    generate
        if (MODE == MODE_PULSE) begin : g_trig_level
            assign trig = req;
        end else begin : g_trig_edge
            logic req_q;
            always_ff @(posedge clk) begin
                if (rst) req_q <= 1'b0;
                else     req_q <= req;
            end
            assign trig = req & ~req_q;
        end
    endgenerate

    assign last = (cnt == LAST_CNT);

    always_comb begin
        nxt.st  = svc_next(cur.st, trig, last);
        nxt.ack = (nxt.st == ST_ACK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.st  <= ST_IDLE;
            cur.ack <= 1'b0;
            cnt     <= '0;
        end else begin
            cur <= nxt;
            if (cur.st == ST_SERVICE && !last)
                cnt <= cnt + CW'(1);
            else
                cnt <= '0;
        end
    end

    assign ack = cur.ack;

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R4
    AST_ACK_FROM_SERVICE: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> ($past(cur.st) == ST_SERVICE)); // R4
    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> !ack); // R1
endmodule

// File: rtl/pc_pulse_sync.sv
module pc_pulse_sync
    import pc_pkg::*;
#(
    parameter catch_mode_e MODE    = MODE_PULSE,
    parameter int unsigned SVC_LEN = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic evt_n,
    output logic req,
    output logic ack
);
    logic src;

    generate
        if (MODE == MODE_PULSE) begin : g_catch
            logic clr;
            logic caught;
            assign clr = rst | ack;
            pc_catch_cell u_catch (
                .clr    (clr),
                .rst_win(rst),
                .evt_n  (evt_n),
                .caught (caught)
            );
            assign src = caught;

            AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
                (req && !ack) |=> (req || ack)); // R3
            AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
                $rose(ack) |-> $past(req)); // R4
        end else begin : g_level
            assign src = ~evt_n;
        end
    endgenerate

    pc_fall_sync u_sync (
        .clk(clk),
        .rst(rst),
        .src(src),
        .req(req)
    );

    pc_consumer #(
        .MODE   (MODE),
        .SVC_LEN(SVC_LEN)
    ) u_consumer (
        .clk(clk),
        .rst(rst),
        .req(req),
        .ack(ack)
    );
endmodule

// File: tb/test_pc_pulse_sync.sv
`timescale 1ns/1ps
module test_pc_pulse_sync;
    import pc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int P_SVC      = 2;
    localparam int L_SVC      = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic evt_p_n = 1'b1;
    logic evt_l_n = 1'b1;
    logic req_p, ack_p, req_l, ack_l;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int packs = 0;
    int lacks = 0;
    int pushed = 0;
    int exp_q[$];
    bit done = 0;

    always #(HALF) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pc_pulse_sync #(.MODE(MODE_PULSE), .SVC_LEN(P_SVC)) i_pc_pulse_sync (
        .clk(clk), .rst(rst), .evt_n(evt_p_n), .req(req_p), .ack(ack_p));

    pc_pulse_sync #(.MODE(MODE_LEVEL), .SVC_LEN(L_SVC)) i_pc_pulse_sync_lvl (
        .clk(clk), .rst(rst), .evt_n(evt_l_n), .req(req_l), .ack(ack_l));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    // monitor: every acknowledge pops one expected item
    always @(negedge clk) begin
        if (!rst && ack_p) begin
            packs++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected ack", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(cyc == e, "R4 ack cycle", cyc, e);
            end
        end
        if (!rst && ack_l) lacks++;
    end

    // driver: pulse starting at offset ns after a rising edge
    task automatic fire(input int offset, input int width);
        @(posedge clk);
        #(offset);
        exp_q.push_back(cyc + 1 + P_SVC + ((offset > HALF) ? 1 : 0));
        pushed++;
        evt_p_n = 1'b0;
        #(width);
        evt_p_n = 1'b1;
    endtask

    task automatic idle_wait();
        repeat (P_SVC + 6) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: event inside reset is discarded
        repeat (2) @(posedge clk);
        #3 evt_p_n = 1'b0;
        #3 evt_p_n = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        #1;
        chk(req_p == 1'b0, "R1 req_p after reset", req_p, 0);
        chk(ack_p == 1'b0, "R1 ack_p after reset", ack_p, 0);
        chk(req_l == 1'b0, "R1 req_l after reset", req_l, 0);
        chk(ack_l == 1'b0, "R1 ack_l after reset", ack_l, 0);
        repeat (6) @(posedge clk);
        #1;
        chk(req_p == 1'b0, "R1 req_p stays low", req_p, 0);
        chk(packs == 0, "R1 no ack from reset event", packs, 0);

        // R2/R3/R5: directed short pulse, first half
        fire(2, 2);
        chk(req_p == 1'b0, "R2 req before falling edge", req_p, 0);
        #3;
        chk(req_p == 1'b1, "R2 req after falling edge", req_p, 1);
        @(posedge clk); #7;
        chk(req_p == 1'b1, "R3 req held in service", req_p, 1);
        @(posedge clk); #7;
        chk(req_p == 1'b1, "R3 req held in service 2", req_p, 1);
        @(posedge clk); #2;
        chk(ack_p == 1'b1, "R4 ack raised", ack_p, 1);
        chk(req_p == 1'b1, "R3 req high until falling edge of ack cycle", req_p, 1);
        #5;
        chk(req_p == 1'b0, "R5 req cleared by ack", req_p, 0);
        @(posedge clk); #2;
        chk(ack_p == 1'b0, "R4 ack one cycle", ack_p, 0);
        idle_wait();

        // R2: 1 ns pulse in second half
        fire(7, 1);
        #1;
        chk(req_p == 1'b0, "R2 narrow pulse not yet sampled", req_p, 0);
        @(negedge clk); #1;
        chk(req_p == 1'b1, "R2 narrow pulse caught", req_p, 1);
        idle_wait();

        // R6: event during acknowledge, first half then second half
        fire(3, 2);
        @(posedge ack_p);
        #1;
        exp_q.push_back(cyc + 1 + P_SVC);
        pushed++;
        evt_p_n = 1'b0; #2 evt_p_n = 1'b1;
        @(posedge ack_p);
        #6;
        exp_q.push_back(cyc + 2 + P_SVC);
        pushed++;
        evt_p_n = 1'b0; #2 evt_p_n = 1'b1;
        idle_wait(); idle_wait();
        chk(exp_q.size() == 0, "R6 ack-time events serviced", exp_q.size(), 0);
        chk(packs == pushed, "R6 ack count", packs, pushed);

        // random widths and offsets
        for (int i = 0; i < 40; i++) begin
            int off;
            int w;
            off = $urandom_range(1, 8);
            if (off >= HALF) off = off + 1;
            w = $urandom_range(1, 8);
            fire(off, w);
            idle_wait();
        end
        idle_wait();
        chk(exp_q.size() == 0, "R4 no missed events", exp_q.size(), 0);
        chk(packs == pushed, "R4 one ack per event", packs, pushed);

        // R7: level mode
        @(posedge clk); #2 evt_l_n = 1'b0;
        #2;
        chk(req_l == 1'b0, "R7 level before falling edge", req_l, 0);
        #3;
        chk(req_l == 1'b1, "R7 level sampled", req_l, 1);
        repeat (8) @(posedge clk);
        #2 evt_l_n = 1'b1;
        #2;
        chk(req_l == 1'b1, "R7 level release not yet sampled", req_l, 1);
        #3;
        chk(req_l == 1'b0, "R7 level release sampled", req_l, 0);
        repeat (4) @(posedge clk);
        chk(lacks == 1, "R7 one ack per level", lacks, 1);
        @(posedge clk); #6 evt_l_n = 1'b0;
        repeat (6) @(posedge clk);
        #2 evt_l_n = 1'b1;
        repeat (4) @(posedge clk);
        chk(lacks == 2, "R7 second level one ack", lacks, 2);
        chk(packs == pushed, "R7 pulse copy untouched", packs, pushed);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule